// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block keeps track of a circular ring of 16-byte receive descriptors in host memory. Software gives the ring's base address, its size in bytes and a tail index. The block keeps the head index. Descriptors from head up to, but not including, tail belong to hardware. The block copies owned descriptors into a 16-entry on-chip cache. It hands their buffer addresses to the receive datapath one packet completion at a time. It then writes the finished descriptors back to host memory with done, end-of-packet and error information filled in.

Three programmable thresholds set the pace of memory traffic. A prefetch starts only when the on-chip stock of unprocessed descriptors is low and enough descriptors are waiting in host memory. Write-back starts once enough processed descriptors have built up. A granularity bit selects whether the thresholds count single descriptors or 64-byte lines of four descriptors.

A four-state machine sequences the memory traffic:
- `ST_IDLE` waits. It takes *start-writeback* to `ST_WRBACK` when the write-back condition holds. Otherwise it takes *start-fetch* to `ST_FETCH` when the prefetch condition holds.
- `ST_FETCH` issues one read per descriptor. It takes *last-read-issued* to `ST_DRAIN`.
- `ST_DRAIN` takes *all-reads-returned* back to `ST_IDLE`.
- `ST_WRBACK` issues one write per processed descriptor. It takes *last-write-issued* to `ST_IDLE`.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset the head index and the hardware-owned count are zero, no memory request is valid, and `cmp_ready` is low.
- R2: The hardware-owned count is (tail − head) modulo the ring size, where the ring size is the length register divided by 16. When head equals tail, no read is issued and `cmp_ready` stays low.
- R3: A prefetch starts from `ST_IDLE` only when all of the following hold:
  - the unprocessed descriptors on chip are fewer than the prefetch threshold;
  - the owned descriptors not yet on chip number at least the host threshold, and at least one;
  - the cache has free space.

  The burst reads min(available, free space) descriptors, one request each, at base + 16·index, with consecutive indices that wrap at the ring size.
- R4: With the granularity bit (control bit 24) at 0, each threshold counts in units of 4 descriptors. With it at 1, each threshold counts single descriptors. The thresholds sit in control bits [5:0] (prefetch), [13:8] (host) and [21:16] (write-back).
- R5: Write-back starts when the processed-but-not-written count is nonzero and reaches the write-back threshold (or the cache depth, if that is smaller). All processed descriptors are then written in ring order. Write-back takes priority over prefetch.
- R6: The head index advances by one for each accepted write-back request and wraps to zero at the ring size. Nothing else moves it while the ring is enabled.
- R7: A written-back descriptor keeps its fetched buffer address in bits [63:0]. Bits [79:64] carry the length, [95:80] the checksum, [103:96] the status byte, [111:104] the error byte and [127:112] the VLAN tag. Status bit 0 (done) is always 1, bit 1 is end-of-packet, bit 3 is VLAN match, bit 7 is inexact-filter pass, and the other status bits are 0.
- R8: The error byte keeps input bits 0 (CRC), 1 (symbol), 2 (sequence), 5 (TCP/UDP), 6 (IPv4) and 7 (receive-data) only on end-of-packet completions. Bits 3 and 4 are always 0, and the whole byte is 0 when end-of-packet is low.
- R9: `cmp_ready` is high while an unprocessed descriptor is on chip. `buf_addr_o` shows the buffer address of the oldest such descriptor. Completions consume descriptors in fetch order.
- R10: The register selectors are 0 base low, 1 base high, 2 length, 3 head, 4 tail and 5 control, with enable in bit 31. Writes to base, length and head are ignored while enabled. Tail and control are always writable. Clearing enable empties the cache once the machine is idle.
- R11: A memory request holds its valid, write flag and address steady until `mem_req_ready`. Read responses return one per read, in order.
- R12: The descriptors cached or in flight never exceed the cache depth or the hardware-owned count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register selector |
| reg_wdata | input | 32 | Register write data |
| head_o | output | IDX_W | Current head index |
| hw_owned_o | output | IDX_W | Descriptors owned by hardware |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write-back, 0 = descriptor read |
| mem_req_addr | output | 64 | Descriptor byte address |
| mem_req_wdata | output | 128 | Descriptor written back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 128 | Descriptor read from memory |
| cmp_valid | input | 1 | Packet completion from the datapath |
| cmp_ready | output | 1 | A descriptor is ready to consume |
| cmp_eop | input | 1 | Last descriptor of the packet |
| cmp_len | input | 16 | Bytes placed in the buffer |
| cmp_csum | input | 16 | Packet checksum |
| cmp_errs | input | 8 | Raw error flags |
| cmp_vlan | input | 16 | VLAN tag |
| cmp_vlan_match | input | 1 | VLAN filter matched |
| cmp_inexact | input | 1 | Passed an inexact address filter |
| buf_addr_o | output | 64 | Buffer address for the next packet |

## Verification
A corrupted cache pointer or ownership count shows up at the memory port within one burst:
- a read lands on a descriptor index outside the owned window;
- a burst has the wrong number of reads;
- `buf_addr_o` names the wrong buffer.

A wrong threshold comparison shows as a missing or extra burst a few cycles after tail or control is written. A head or wrap fault moves `head_o` and the write-back addresses off the expected sequence at the next accepted write. The sweep checks burst sizes over every tail position and threshold pairs in both granularities.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int BUF_AW = 64;
    localparam int DESC_W = 128;

    // register selectors
    localparam logic [2:0] RSEL_BASE_LO = 3'd0;
    localparam logic [2:0] RSEL_BASE_HI = 3'd1;
    localparam logic [2:0] RSEL_LEN     = 3'd2;
    localparam logic [2:0] RSEL_HEAD    = 3'd3;
    localparam logic [2:0] RSEL_TAIL    = 3'd4;
    localparam logic [2:0] RSEL_CTRL    = 3'd5;

    localparam int CTRL_PTH_LSB  = 0;
    localparam int CTRL_HTH_LSB  = 8;
    localparam int CTRL_WTH_LSB  = 16;
    localparam int CTRL_GRAN_BIT = 24;
    localparam int CTRL_EN_BIT   = 31;

    // error bits kept on end-of-packet: all but bits 3 and 4
    localparam logic [7:0] ERR_KEEP = 8'hE7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_WRBACK
    } rxr_state_e;

    typedef struct packed {
        logic [15:0] vlan;
        logic [7:0]  errs;
        logic [7:0]  stat;
        logic [15:0] csum;
        logic [15:0] plen;
    } rxr_info_t;

    typedef struct packed {
        rxr_info_t   info;
        logic [63:0] baddr;
    } rxr_desc_t;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int IDX_W = 12,
    parameter int TH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             head_adv,
    output logic [63:0]      base,
    output logic [IDX_W-1:0] ring_n,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [TH_W-1:0]  pth,
    output logic [TH_W-1:0]  hth,
    output logic [TH_W-1:0]  wth,
    output logic             gran,
    output logic             en
);
    localparam int LEN_W = IDX_W + 4;

    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] head_inc;

    assign ring_n   = len_q[LEN_W-1:4];
    assign head_inc = head + IDX_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base  <= '0;
            len_q <= '0;
            head  <= '0;
            tail  <= '0;
            pth   <= '0;
            hth   <= '0;
            wth   <= '0;
            gran  <= 1'b0;
            en    <= 1'b0;
        end else begin
            if (we) begin
                case (addr)
                    RSEL_BASE_LO: if (!en) base[31:0]  <= {wdata[31:4], 4'b0000};
                    RSEL_BASE_HI: if (!en) base[63:32] <= wdata;
                    RSEL_LEN:     if (!en) len_q       <= wdata[LEN_W-1:0];
                    RSEL_HEAD:    if (!en) head        <= wdata[IDX_W-1:0];
                    RSEL_TAIL:    tail <= wdata[IDX_W-1:0];
                    RSEL_CTRL: begin
                        pth  <= wdata[CTRL_PTH_LSB +: TH_W];
                        hth  <= wdata[CTRL_HTH_LSB +: TH_W];
                        wth  <= wdata[CTRL_WTH_LSB +: TH_W];
                        gran <= wdata[CTRL_GRAN_BIT];
                        en   <= wdata[CTRL_EN_BIT];
                    end
                    default: ;
                endcase
            end
            if (head_adv) begin
                head <= (head_inc == ring_n) ? '0 : head_inc;
            end
        end
    end
endmodule

// File: rtl/rxr_desc_cache.sv
module rxr_desc_cache
    import rxr_pkg::*;
#(
    parameter int DEPTH = 16,          // power of two
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          req_acc,
    input  logic          rsp_valid,
    input  logic [63:0]   rsp_baddr,
    input  logic          cmp_acc,
    input  rxr_info_t     cmp_info,
    input  logic          wb_acc,
    output logic [CW-1:0] occupied,
    output logic [CW-1:0] unproc,
    output logic [CW-1:0] done_cnt,
    output logic [CW-1:0] inflight,
    output logic [63:0]   cur_baddr,
    output rxr_desc_t     wb_desc
);
    logic [CW-1:0] req_p, rsp_p, cmp_p, wb_p;
    logic [63:0]   baddr_m [DEPTH];
    rxr_info_t     info_m  [DEPTH];

    always_ff @(posedge clk) begin
        if (rsp_valid) baddr_m[rsp_p[PW-1:0]] <= rsp_baddr;
        if (cmp_acc)   info_m[cmp_p[PW-1:0]]  <= cmp_info;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_p <= '0;
            rsp_p <= '0;
            cmp_p <= '0;
            wb_p  <= '0;
        end else if (flush) begin
            req_p <= '0;
            rsp_p <= '0;
            cmp_p <= '0;
            wb_p  <= '0;
        end else begin
            if (req_acc)   req_p <= req_p + CW'(1);
            if (rsp_valid) rsp_p <= rsp_p + CW'(1);
            if (cmp_acc)   cmp_p <= cmp_p + CW'(1);
            if (wb_acc)    wb_p  <= wb_p + CW'(1);
        end
    end

    assign occupied  = req_p - wb_p;
    assign inflight  = req_p - rsp_p;
    assign unproc    = rsp_p - cmp_p;
    assign done_cnt  = cmp_p - wb_p;
    assign cur_baddr = baddr_m[cmp_p[PW-1:0]];
    assign wb_desc   = {info_m[wb_p[PW-1:0]], baddr_m[wb_p[PW-1:0]]};
endmodule

// File: rtl/rxr_ring_math.sv
module rxr_ring_math #(
    parameter int IDX_W = 12,
    parameter int CW    = 5
) (
    input  logic [63:0]      base,
    input  logic [IDX_W-1:0] ring_n,
    input  logic [IDX_W-1:0] head,
    input  logic [IDX_W-1:0] tail,
    input  logic [CW-1:0]    occupied,
    output logic [IDX_W-1:0] owned,
    output logic [IDX_W-1:0] avail,
    output logic [63:0]      fetch_addr,
    output logic [63:0]      wb_addr
);
    logic [IDX_W:0]   wrap_sum;
    logic [IDX_W:0]   fsum;
    logic [IDX_W-1:0] occ_x;
    logic [IDX_W-1:0] fidx;

    always_comb begin
        wrap_sum = {1'b0, tail} + {1'b0, ring_n} - {1'b0, head};
        if (tail >= head) owned = tail - head;
        else              owned = wrap_sum[IDX_W-1:0];

        occ_x = IDX_W'(occupied);
        avail = (occ_x > owned) ? '0 : owned - occ_x;

        fsum = {1'b0, head} + {1'b0, occ_x};
        if (fsum >= {1'b0, ring_n}) fsum = fsum - {1'b0, ring_n};
        fidx = fsum[IDX_W-1:0];

        fetch_addr = base + 64'({fidx, 4'b0000});
        wb_addr    = base + 64'({head, 4'b0000});
    end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
    import rxr_pkg::*;
#(
    parameter int IDX_W       = 12,
    parameter int TH_W        = 6,
    parameter int CACHE_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] hw_owned_o,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_we,
    output logic [63:0]      mem_req_addr,
    output logic [127:0]     mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [127:0]     mem_rsp_rdata,
    input  logic             cmp_valid,
    output logic             cmp_ready,
    input  logic             cmp_eop,
    input  logic [15:0]      cmp_len,
    input  logic [15:0]      cmp_csum,
    input  logic [7:0]       cmp_errs,
    input  logic [15:0]      cmp_vlan,
    input  logic             cmp_vlan_match,
    input  logic             cmp_inexact,
    output logic [63:0]      buf_addr_o
);
    localparam int PW    = $clog2(CACHE_DEPTH);
    localparam int CW    = PW + 1;
    localparam int THD_W = TH_W + 2;
    localparam int N_TH  = 3;

    rxr_state_e state_q, state_d;

    logic [63:0]      base;
    logic [IDX_W-1:0] ring_n, head, tail, owned, avail;
    logic [TH_W-1:0]  pth, hth, wth;
    logic             gran, en;
    logic [CW-1:0]    occupied, unproc, done_cnt, inflight, free_sp, fetch_n, left_q;
    logic [63:0]      fetch_addr, wb_addr, cur_baddr;
    rxr_desc_t        wb_desc;
    rxr_info_t        cmp_info;
    logic             req_acc, wb_acc, cmp_acc, flush, wb_go, pf_go;
    logic             unused_rsp_hi;

    logic [TH_W-1:0]  th_raw  [N_TH];
    logic [THD_W-1:0] th_desc [N_TH];

    assign unused_rsp_hi = ^mem_rsp_rdata[127:64];

    rxr_regs #(.IDX_W(IDX_W), .TH_W(TH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .head_adv(wb_acc), .base(base), .ring_n(ring_n), .head(head), .tail(tail),
        .pth(pth), .hth(hth), .wth(wth), .gran(gran), .en(en)
    );

    rxr_desc_cache #(.DEPTH(CACHE_DEPTH)) u_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_acc(req_acc),
        .rsp_valid(mem_rsp_valid), .rsp_baddr(mem_rsp_rdata[63:0]),
        .cmp_acc(cmp_acc), .cmp_info(cmp_info), .wb_acc(wb_acc),
        .occupied(occupied), .unproc(unproc), .done_cnt(done_cnt), .inflight(inflight),
        .cur_baddr(cur_baddr), .wb_desc(wb_desc)
    );

    rxr_ring_math #(.IDX_W(IDX_W), .CW(CW)) u_math (
        .base(base), .ring_n(ring_n), .head(head), .tail(tail), .occupied(occupied),
        .owned(owned), .avail(avail), .fetch_addr(fetch_addr), .wb_addr(wb_addr)
    );

    // threshold scaling: granularity 0 counts 4-descriptor lines
    assign th_raw[0] = pth;
    assign th_raw[1] = hth;
    assign th_raw[2] = wth;
    for (genvar gi = 0; gi < N_TH; gi++) begin : g_th
        assign th_desc[gi] = gran ? {2'b00, th_raw[gi]} : {th_raw[gi], 2'b00};
    end

    assign free_sp = CW'(CACHE_DEPTH) - occupied;
    assign fetch_n = (32'(avail) < 32'(free_sp)) ? CW'(avail) : free_sp;
    assign wb_go   = (done_cnt != '0) &&
                     ((32'(done_cnt) >= 32'(th_desc[2])) || (32'(done_cnt) >= CACHE_DEPTH));
    assign pf_go   = (32'(unproc) < 32'(th_desc[0])) && (32'(avail) >= 32'(th_desc[1])) &&
                     (avail != '0) && (free_sp != '0);

    // completion path
    assign cmp_ready = en && (unproc != '0);
    assign cmp_acc   = cmp_valid && cmp_ready;
    always_comb begin
        cmp_info.vlan = cmp_vlan;
        cmp_info.errs = cmp_eop ? (cmp_errs & ERR_KEEP) : 8'h00;
        cmp_info.stat = {cmp_inexact, 3'b000, cmp_vlan_match, 1'b0, cmp_eop, 1'b1};
        cmp_info.csum = cmp_csum;
        cmp_info.plen = cmp_len;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en && wb_go)      state_d = ST_WRBACK;
                else if (en && pf_go) state_d = ST_FETCH;
            end
            ST_FETCH:  if (mem_req_ready && left_q == CW'(1)) state_d = ST_DRAIN;
            ST_DRAIN:  if (inflight == '0) state_d = ST_IDLE;
            ST_WRBACK: if (mem_req_ready && left_q == CW'(1)) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // burst length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (state_q == ST_IDLE && en) begin
            if (wb_go)      left_q <= done_cnt;
            else if (pf_go) left_q <= fetch_n;
        end else if (req_acc || wb_acc) begin
            left_q <= left_q - CW'(1);
        end
    end

    // outputs
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = fetch_addr;
        req_acc       = 1'b0;
        wb_acc        = 1'b0;
        flush         = 1'b0;
        unique case (state_q)
            ST_IDLE:  flush = !en;
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                req_acc       = mem_req_ready;
            end
            ST_DRAIN: ;
            ST_WRBACK: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = wb_addr;
                wb_acc        = mem_req_ready;
            end
            default: ;
        endcase
    end

    assign mem_req_wdata = wb_desc;
    assign head_o        = head;
    assign hw_owned_o    = owned;
    assign buf_addr_o    = cur_baddr;
endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk #(
    parameter int IDX_W = 12,
    parameter int CW    = 5,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [IDX_W-1:0] head,
    input logic [IDX_W-1:0] owned,
    input logic [CW-1:0]    occupied,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_we,
    input logic [63:0]      req_addr,
    input logic [127:0]     req_wdata,
    input logic             cmp_ready
);
    AST_RST_QUIET: assert property (@(posedge clk) !rst_n |-> !req_valid && !cmp_ready); // R1
    AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        owned == '0 |-> !(req_valid && !req_we) && !cmp_ready); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_we) && $stable(req_addr)); // R11
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && head != $past(head) |-> $past(req_valid && req_ready && req_we)); // R6
    AST_WB_DONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_we |-> req_wdata[96] && req_wdata[98] == 1'b0); // R7
    AST_ERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_we && !req_wdata[97] |-> req_wdata[111:104] == 8'h00); // R8
    AST_ERR_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_we |-> req_wdata[108:107] == 2'b00); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        32'(occupied) <= DEPTH); // R12
    AST_WITHIN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        32'(occupied) <= 32'(owned)); // R12
endmodule

bind rx_desc_ring rx_desc_ring_chk #(.IDX_W(IDX_W), .CW(CW), .DEPTH(CACHE_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .head(head_o), .owned(hw_owned_o),
    .occupied(occupied), .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_we(mem_req_we), .req_addr(mem_req_addr), .req_wdata(mem_req_wdata),
    .cmp_ready(cmp_ready)
);

// File: tb/rx_desc_ring_bench.sv
module rx_desc_ring_bench;
    localparam int IDX_W = 12;
    localparam logic [63:0] BASE = 64'h1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [IDX_W-1:0] head_o, hw_owned_o;
    logic mem_req_valid, mem_req_we;
    logic mem_req_ready = 1'b1;
    logic [63:0] mem_req_addr;
    logic [127:0] mem_req_wdata;
    logic mem_rsp_valid;
    logic [127:0] mem_rsp_rdata;
    logic cmp_valid = 1'b0, cmp_eop = 1'b0, cmp_vlan_match = 1'b0, cmp_inexact = 1'b0;
    logic cmp_ready;
    logic [15:0] cmp_len = '0, cmp_csum = '0, cmp_vlan = '0;
    logic [7:0] cmp_errs = '0;
    logic [63:0] buf_addr_o;

    int errors = 0;
    int checks = 0;

    logic [127:0] hmem [64];
    int rd_cnt, wb_cnt;
    int rd_log [1024];
    int wb_log [1024];

    always #5 clk = ~clk;

    rx_desc_ring u_rx_desc_ring (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .head_o(head_o), .hw_owned_o(hw_owned_o), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_eop(cmp_eop), .cmp_len(cmp_len),
        .cmp_csum(cmp_csum), .cmp_errs(cmp_errs), .cmp_vlan(cmp_vlan),
        .cmp_vlan_match(cmp_vlan_match), .cmp_inexact(cmp_inexact), .buf_addr_o(buf_addr_o)
    );

    function automatic logic [63:0] bufa(int i);
        return 64'hA000_0000_0000_0000 | (64'(i) << 11);
    endfunction

    // host memory model: one-cycle read latency
    always @(posedge clk) begin
        int idx;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) hmem[i] <= {64'hFFFF_FFFF_FFFF_FFFF, bufa(i)};
            rd_cnt <= 0;
            wb_cnt <= 0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_rdata <= '0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                idx = int'((mem_req_addr - BASE) >> 4) & 63;
                if (!mem_req_we) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= hmem[idx];
                    rd_log[rd_cnt & 1023] <= idx;
                    rd_cnt <= rd_cnt + 1;
                end else begin
                    hmem[idx] <= mem_req_wdata;
                    wb_log[wb_cnt & 1023] <= idx;
                    wb_cnt <= wb_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctrl(bit e, bit g, int w, int h, int p);
        return {e, 6'd0, g, 2'd0, 6'(w), 2'd0, 6'(h), 2'd0, 6'(p)};
    endfunction

    task automatic complete(input bit eop, input logic [7:0] er, input logic [15:0] vl,
                            input bit vp, input bit pif, input logic [15:0] ln, input logic [15:0] cs);
        int guard = 0;
        @(negedge clk);
        while (!cmp_ready && guard < 100) begin @(negedge clk); guard++; end
        cmp_valid = 1'b1; cmp_eop = eop; cmp_errs = er; cmp_vlan = vl;
        cmp_vlan_match = vp; cmp_inexact = pif; cmp_len = ln; cmp_csum = cs;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 head", 64'(head_o), 0);
        chk("R1 owned", 64'(hw_owned_o), 0);
        chk("R1 req_valid", 64'(mem_req_valid), 0);
        chk("R1 cmp_ready", 64'(cmp_ready), 0);
        rst_n = 1'b1;

        wreg(3'd0, 32'h1000); wreg(3'd1, 0); wreg(3'd2, 256);
        wreg(3'd3, 0); wreg(3'd4, 0);
        wreg(3'd5, ctrl(1, 1, 1, 1, 4));
        settle(20);
        // R2 empty ring
        chk("R2 no reads when head==tail", 64'(rd_cnt), 0);
        chk("R2 cmp_ready low", 64'(cmp_ready), 0);

        // R3 fetch of 5
        wreg(3'd4, 5);
        settle(20);
        chk("R3 read count", 64'(rd_cnt), 5);
        chk("R3 first index", 64'(rd_log[0]), 0);
        chk("R3 last index", 64'(rd_log[4]), 4);
        chk("R2 owned", 64'(hw_owned_o), 5);
        chk("R9 cmp_ready", 64'(cmp_ready), 1);
        chk("R9 buf addr", buf_addr_o, bufa(0));

        // R7 R8 eop completion
        complete(1, 8'hFF, 16'h0123, 1, 1, 16'd60, 16'hBEEF);
        settle(10);
        chk("R7 baddr kept", hmem[0][63:0], bufa(0));
        chk("R7 length", 64'(hmem[0][79:64]), 60);
        chk("R7 checksum", 64'(hmem[0][95:80]), 16'hBEEF);
        chk("R7 status", 64'(hmem[0][103:96]), 8'h8B);
        chk("R8 errors eop", 64'(hmem[0][111:104]), 8'hE7);
        chk("R7 vlan", 64'(hmem[0][127:112]), 16'h0123);
        chk("R6 head", 64'(head_o), 1);
        chk("R9 next buf", buf_addr_o, bufa(1));

        complete(0, 8'hFF, 16'h0, 0, 0, 16'd1500, 16'h1);
        settle(10);
        chk("R7 status no eop", 64'(hmem[1][103:96]), 8'h01);
        chk("R8 errors cleared", 64'(hmem[1][111:104]), 0);
        chk("R6 head 2", 64'(head_o), 2);

        // R5 write-back threshold 3
        wreg(3'd5, ctrl(1, 1, 3, 1, 4));
        complete(1, 0, 0, 0, 0, 10, 0);
        complete(1, 0, 0, 0, 0, 11, 0);
        settle(10);
        chk("R5 below threshold", 64'(head_o), 2);
        complete(1, 0, 0, 0, 0, 12, 0);
        settle(10);
        chk("R5 burst written", 64'(head_o), 5);
        chk("R5 order", 64'(wb_log[wb_cnt - 1]), 4);
        chk("R2 owned zero", 64'(hw_owned_o), 0);

        // R3 host threshold
        wreg(3'd5, ctrl(1, 1, 1, 4, 4));
        wreg(3'd4, 8);
        settle(15);
        chk("R3 host threshold blocks", 64'(rd_cnt), 5);
        wreg(3'd4, 9);
        settle(15);
        chk("R3 host threshold met", 64'(rd_cnt), 9);
        chk("R3 index", 64'(rd_log[8]), 8);

        // R6 wrap
        for (int i = 0; i < 4; i++) complete(1, 0, 0, 0, 0, 16'(i), 0);
        settle(10);
        chk("R6 head 9", 64'(head_o), 9);
        wreg(3'd4, 3);
        settle(25);
        chk("R3 wrap count", 64'(rd_cnt), 19);
        chk("R3 index 15", 64'(rd_log[15]), 15);
        chk("R3 index wraps", 64'(rd_log[16]), 0);
        for (int i = 0; i < 10; i++) complete(1, 0, 0, 0, 0, 16'(i), 0);
        settle(10);
        chk("R6 head wrapped", 64'(head_o), 3);
        chk("R6 last wb index", 64'(wb_log[wb_cnt - 1]), 2);

        // R10 head ignored while enabled
        wreg(3'd3, 7);
        settle(3);
        chk("R10 head write ignored", 64'(head_o), 3);

        // R11 stalled memory
        wreg(3'd5, ctrl(1, 1, 1, 1, 4));
        mem_req_ready = 1'b0;
        wreg(3'd4, 6);
        settle(10);
        chk("R11 no accept", 64'(rd_cnt), 19);
        chk("R11 request held", 64'(mem_req_valid), 1);
        mem_req_ready = 1'b1;
        settle(15);
        chk("R11 resumed", 64'(rd_cnt), 22);
        chk("R11 index", 64'(rd_log[21]), 5);

        // R12 cache depth limits burst
        wreg(3'd5, ctrl(0, 1, 1, 1, 20));
        settle(3);
        wreg(3'd2, 512); wreg(3'd3, 0); wreg(3'd4, 20);
        r0 = rd_cnt;
        wreg(3'd5, ctrl(1, 1, 1, 1, 20));
        settle(30);
        chk("R12 burst capped", 64'(rd_cnt - r0), 16);
        chk("R9 buf after flush", buf_addr_o, bufa(0));
        complete(1, 0, 0, 0, 0, 1, 0);
        settle(20);
        chk("R12 refill one", 64'(rd_cnt - r0), 17);
        chk("R12 refill index", 64'(rd_log[(rd_cnt - 1) & 1023]), 16);
        chk("R9 in order", buf_addr_o, bufa(1));

        // R3 R4 sweep: tail x thresholds x granularity
        wreg(3'd5, ctrl(0, 1, 1, 1, 1));
        settle(3);
        wreg(3'd2, 256);
        for (int g = 0; g < 2; g++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int hi = 0; hi < 5; hi++) begin
                    for (int t = 0; t < 16; t++) begin
                        int p, h, pd, hd, exp_n;
                        p = (pi == 0) ? 0 : (pi == 1) ? 1 : 4;
                        h = (hi == 0) ? 0 : (hi == 1) ? 1 : (hi == 2) ? 3 : (hi == 3) ? 4 : 9;
                        pd = g ? p : 4 * p;
                        hd = g ? h : 4 * h;
                        exp_n = (t > 0 && pd > 0 && t >= hd) ? t : 0;
                        wreg(3'd5, ctrl(0, g[0], 1, h, p));
                        settle(2);
                        wreg(3'd3, 0);
                        wreg(3'd4, 32'(t));
                        r0 = rd_cnt;
                        wreg(3'd5, ctrl(1, g[0], 1, h, p));
                        settle(25);
                        chk($sformatf("R4 sweep g=%0d p=%0d h=%0d t=%0d", g, p, h, t),
                            64'(rd_cnt - r0), 64'(exp_n));
                    end
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule